// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block holds the receive and transmit byte queues of a serial port together with the interrupt logic that a host driver services. The receive shifter hands in bytes with a one-cycle push strobe. The transmit shifter takes bytes from the head of the transmit queue with a pop strobe. A one-cycle character-time strobe from the baud logic paces the receive timeout. The shifters and the baud generator are outside the block.

Software reaches the block through a small word-wide register port with four addresses. The data address pops received bytes and pushes bytes to send. The interrupt address holds five mask bits next to five status bits. The control address holds the two fill thresholds, the timeout length and the transmit fill level, plus two self-clearing queue-reset bits. A single level interrupt output is raised when any status bit is set and its mask bit is also set. Receive overflow is sticky: it can only be cleared by resetting the receive queue.

Top module: `uif_ctrl`

## Requirements
- R1: After a synchronous reset both queues are empty and all mask bits are 0. Both thresholds reset to DEPTH/2 and the timeout field resets to 1. The irq output is 0, the interrupt register reads 0x1800 and the control register reads 0x0001_0808.
- R2: Bytes pushed on rx_push are returned in arrival order. A read at address 0 returns the oldest byte in bits [7:0] with bit 8 set, and removes that byte. When the queue is empty the read returns 0 and removes nothing.
- R3: When rx_push arrives and the receive queue holds DEPTH bytes at that clock edge, the byte is dropped and overflow status (interrupt register bit 8, source 0) is set. This holds even if a read pops the queue in the same cycle. The bit then stays set through reads and mask writes.
- R4: Receive level status (bit 9) is 1 exactly when the receive fill count is at least the receive threshold (control bits [4:0]).
- R5: A timeout counter advances on each char_tick while the receive queue is non-empty and its fill is below the receive threshold. It restarts on any rx_push, on any read at address 0, and on a receive reset. Timeout status (bit 10) is 1 when the count has reached the timeout field (control bits [19:16]) under those same conditions. A field value of 0 disables it.
- R6: Transmit empty status (bit 11) is 1 when the transmit queue is empty. Transmit low status (bit 12) is 1 when the transmit fill is below the transmit threshold (control bits [12:8]).
- R7: A write to address 0 appends wdata[7:0] to the transmit queue, and is dropped when the queue is full. tx_valid shows that the queue is non-empty and tx_head shows its oldest byte. tx_pop removes that byte.
- R8: Control bits [28:24] read back the current transmit fill count (0 to DEPTH).
- R9: Writing control bit 30 empties the receive queue and clears overflow. Writing bit 31 empties the transmit queue. The same write also loads the threshold and timeout fields. Both reset bits read back as 0.
- R10: Writes to address 1 load the mask bits [4:0] and leave status bits [12:8] unchanged. Bit 13 reads 1 when the receive queue is non-empty. Address 3 reads 0.
- R11: irq is the OR, over all five sources, of status AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_data | input | 8 | Byte delivered with rx_push |
| char_tick | input | 1 | One-cycle strobe per character time |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_head | output | 8 | Oldest byte in the transmit queue |
| tx_valid | output | 1 | Transmit queue non-empty |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 0) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the receive timeout. It needs a queue that is partly filled below the threshold, followed by a run of character ticks with no push and no data read in between. A read at the wrong moment silently restarts the count. The directed part of the stimulus sets a short timeout and pushes a single byte. It then issues only ticks and reads of the interrupt register, which do not pop. After that it pushes again to show the restart. A long random phase then mixes pushes, ticks, pops, threshold rewrites and queue resets. A cycle-level queue model checks every output in every cycle of that phase.

// File: rtl/uif_pkg.sv
package uif_pkg;

    localparam int DEPTH_DEF = 16;
    localparam int DW_DEF    = 8;
    localparam int TMO_W_DEF = 4;
    localparam int NSRC      = 5;

    // register map
    typedef enum logic [1:0] {
        A_DATA  = 2'd0,
        A_IRQ   = 2'd1,
        A_CTRL  = 2'd2,
        A_SPARE = 2'd3
    } reg_addr_e;

    // field positions
    localparam int ST_LSB     = 8;
    localparam int RXNE_BIT   = 13;
    localparam int RXTHR_LSB  = 0;
    localparam int TXTHR_LSB  = 8;
    localparam int TMO_LSB    = 16;
    localparam int TXFILL_LSB = 24;
    localparam int RXRST_BIT  = 30;
    localparam int TXRST_BIT  = 31;

    // one bit per interrupt source, source 0 in the LSB
    typedef struct packed {
        logic tx_low;
        logic tx_empty;
        logic rx_tmo;
        logic rx_lvl;
        logic rx_ovf;
    } irq_vec_t;

    function automatic logic any_pending(input irq_vec_t st, input irq_vec_t msk);
        return |(st & msk);
    endfunction

endpackage

// File: rtl/uif_fifo.sv
module uif_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + PW'(1);
            if (pop_ok)  rp <= rp + PW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wp] <= wdata;
    end

endmodule

// File: rtl/uif_rxtimer.sv
module uif_rxtimer #(
    parameter int TMO_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic             arm,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt;
    logic             at_max;

    assign at_max  = (cnt == {TMO_W{1'b1}});
    assign expired = arm && (limit != '0) && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick && arm && !at_max) begin
            cnt <= cnt + TMO_W'(1);
        end
    end

endmodule

// File: rtl/uif_irqlogic.sv
module uif_irqlogic
    import uif_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ovf_set,
    input  logic          ovf_clr,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_thr,
    input  logic [CW-1:0] tx_thr,
    input  logic          tmo_hit,
    input  irq_vec_t      mask,
    output irq_vec_t      status,
    output logic          irq
);

    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst || ovf_clr) ovf_q <= 1'b0;
        else if (ovf_set)   ovf_q <= 1'b1;
    end

    always_comb begin
        status.rx_ovf   = ovf_q;
        status.rx_lvl   = (rx_cnt >= rx_thr);
        status.rx_tmo   = tmo_hit;
        status.tx_empty = (tx_cnt == '0);
        status.tx_low   = (tx_cnt < tx_thr);
    end

    assign irq = any_pending(status, mask);

endmodule

// File: rtl/uif_ctrl.sv
module uif_ctrl
    import uif_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int DW    = DW_DEF,
    parameter int TMO_W = TMO_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_data,
    input  logic          char_tick,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_head,
    output logic          tx_valid,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq
);

    localparam int CW = $clog2(DEPTH) + 1;

    reg_addr_e        addr_e;
    logic             wr_data, wr_irq, wr_ctrl, rd_data;
    logic             rx_clr, tx_clr;
    irq_vec_t         mask_q, st;
    logic [CW-1:0]    rxthr_q, txthr_q;
    logic [TMO_W-1:0] tmo_q;
    logic [DW-1:0]    rx_head;
    logic [CW-1:0]    rx_cnt, tx_cnt;
    logic             rx_full, rx_empty, tx_full, tx_empty;
    logic             tmo_arm, tmo_hit;
    logic             wdata_unused;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign wr_data = reg_wr && (addr_e == A_DATA);
    assign wr_irq  = reg_wr && (addr_e == A_IRQ);
    assign wr_ctrl = reg_wr && (addr_e == A_CTRL);
    assign rd_data = reg_rd && (addr_e == A_DATA);
    assign rx_clr  = wr_ctrl && reg_wdata[RXRST_BIT];
    assign tx_clr  = wr_ctrl && reg_wdata[TXRST_BIT];
    assign wdata_unused = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            rxthr_q <= CW'(DEPTH / 2);
            txthr_q <= CW'(DEPTH / 2);
            tmo_q   <= TMO_W'(1);
        end else begin
            if (wr_irq) mask_q <= irq_vec_t'(reg_wdata[NSRC-1:0]);
            if (wr_ctrl) begin
                rxthr_q <= reg_wdata[RXTHR_LSB +: CW];
                txthr_q <= reg_wdata[TXTHR_LSB +: CW];
                tmo_q   <= reg_wdata[TMO_LSB +: TMO_W];
            end
        end
    end

    uif_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(rx_push), .pop(rd_data), .wdata(rx_data),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    uif_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(wr_data), .pop(tx_pop), .wdata(reg_wdata[DW-1:0]),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    assign tx_valid = !tx_empty;
    assign tmo_arm  = !rx_empty && (rx_cnt < rxthr_q);

    uif_rxtimer #(.TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst(rst),
        .restart(rx_push || rd_data || rx_clr),
        .tick(char_tick), .arm(tmo_arm), .limit(tmo_q),
        .expired(tmo_hit)
    );

    uif_irqlogic #(.CW(CW)) u_irq (
        .clk(clk), .rst(rst),
        .ovf_set(rx_push && rx_full), .ovf_clr(rx_clr),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
        .rx_thr(rxthr_q), .tx_thr(txthr_q),
        .tmo_hit(tmo_hit), .mask(mask_q),
        .status(st), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (addr_e)
            A_DATA: begin
                if (!rx_empty) begin
                    reg_rdata[DW-1:0] = rx_head;
                    reg_rdata[DW]     = 1'b1;
                end
            end
            A_IRQ: begin
                reg_rdata[NSRC-1:0]        = mask_q;
                reg_rdata[ST_LSB +: NSRC]  = st;
                reg_rdata[RXNE_BIT]        = !rx_empty;
            end
            A_CTRL: begin
                reg_rdata[RXTHR_LSB +: CW]  = rxthr_q;
                reg_rdata[TXTHR_LSB +: CW]  = txthr_q;
                reg_rdata[TMO_LSB +: TMO_W] = tmo_q;
                reg_rdata[TXFILL_LSB +: CW] = tx_cnt;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uif_ctrl_chk.sv
module uif_ctrl_chk
    import uif_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_push,
    input logic          rd_pop,
    input logic          rx_clr,
    input logic          tx_clr,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input irq_vec_t      st,
    input irq_vec_t      mask,
    input logic          irq
);

    p_rx_cap_r2: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CW'(DEPTH));

    p_tx_cap_r7: assert property (@(posedge clk) disable iff (rst)
        tx_cnt <= CW'(DEPTH));

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
        rx_push && (rx_cnt == CW'(DEPTH)) && !rx_clr |=> st.rx_ovf);

    p_ovf_hold_r3: assert property (@(posedge clk) disable iff (rst)
        st.rx_ovf && !rx_clr |=> st.rx_ovf);

    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        rx_push && (rx_cnt == CW'(DEPTH)) && !rd_pop && !rx_clr |=> rx_cnt == CW'(DEPTH));

    p_rx_reset_r9: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> (rx_cnt == '0) && !st.rx_ovf);

    p_tx_reset_r9: assert property (@(posedge clk) disable iff (rst)
        tx_clr |=> tx_cnt == '0);

    p_tmo_restart_r5: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !st.rx_tmo);

    p_mask_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

endmodule

bind uif_ctrl uif_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rd_pop(rd_data),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .st(st), .mask(mask_q), .irq(irq)
);

// File: tb/tb_uif_ctrl.sv
module tb_uif_ctrl;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_push = 0, char_tick = 0, tx_pop = 0, reg_wr = 0, reg_rd = 0;
    logic [7:0]  rx_data = '0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  tx_head;
    logic        tx_valid, irq;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    int m_ovf, m_mask, m_rxthr, m_txthr, m_tmo, m_tcnt;

    uif_ctrl dut (
        .clk(clk), .rst(rst), .rx_push(rx_push), .rx_data(rx_data),
        .char_tick(char_tick), .tx_pop(tx_pop), .tx_head(tx_head),
        .tx_valid(tx_valid), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        bit rxclr, txclr, rdpop, rxfull, txfull, arm;
        int rsz;
        if (rst) begin
            rxq.delete(); txq.delete();
            m_ovf = 0; m_mask = 0; m_rxthr = DEPTH/2; m_txthr = DEPTH/2;
            m_tmo = 1; m_tcnt = 0;
        end else begin
            rxclr = reg_wr && reg_addr == 2 && reg_wdata[30];
            txclr = reg_wr && reg_addr == 2 && reg_wdata[31];
            rdpop = reg_rd && reg_addr == 0;
            rsz = rxq.size();
            arm = rsz > 0 && rsz < m_rxthr;
            if (rx_push || rdpop || rxclr) m_tcnt = 0;
            else if (char_tick && arm && m_tcnt < 15) m_tcnt++;
            if (rxclr) begin
                rxq.delete(); m_ovf = 0;
            end else begin
                rxfull = (rsz == DEPTH);
                if (rdpop && rsz > 0) void'(rxq.pop_front());
                if (rx_push) begin
                    if (rxfull) m_ovf = 1;
                    else rxq.push_back(rx_data);
                end
            end
            if (txclr) txq.delete();
            else begin
                txfull = (txq.size() == DEPTH);
                if (tx_pop && txq.size() > 0) void'(txq.pop_front());
                if (reg_wr && reg_addr == 0 && !txfull) txq.push_back(reg_wdata[7:0]);
            end
            if (reg_wr && reg_addr == 1) m_mask = int'(reg_wdata[4:0]);
            if (reg_wr && reg_addr == 2) begin
                m_rxthr = int'(reg_wdata[4:0]);
                m_txthr = int'(reg_wdata[12:8]);
                m_tmo   = int'(reg_wdata[19:16]);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] m_status();
        logic [4:0] s;
        int rsz = rxq.size();
        bit arm = rsz > 0 && rsz < m_rxthr;
        s[0] = m_ovf != 0;
        s[1] = rsz >= m_rxthr;
        s[2] = arm && m_tmo != 0 && m_tcnt >= m_tmo;
        s[3] = txq.size() == 0;
        s[4] = txq.size() < m_txthr;
        return s;
    endfunction

    task automatic compare();
        logic [4:0]  s = m_status();
        logic [31:0] e = '0;
        chk("R11", 32'(irq), 32'(|(s & 5'(m_mask))));
        chk("R7", 32'(tx_valid), 32'(txq.size() > 0));
        if (txq.size() > 0) chk("R7", 32'(tx_head), 32'(txq[0]));
        case (reg_addr)
            2'd0: begin
                if (rxq.size() > 0) e = {23'd0, 1'b1, rxq[0]};
                chk("R2", reg_rdata, e);
            end
            2'd1: begin
                e[4:0] = 5'(m_mask); e[12:8] = s; e[13] = rxq.size() > 0;
                chk("R10", reg_rdata, e);
            end
            2'd2: begin
                e[4:0] = 5'(m_rxthr); e[12:8] = 5'(m_txthr);
                e[19:16] = 4'(m_tmo); e[28:24] = 5'(txq.size());
                chk("R8", reg_rdata, e);
            end
            default: chk("R10", reg_rdata, 32'd0);
        endcase
    endtask

    task automatic cyc(input bit push, input logic [7:0] pd, input bit tick,
                       input bit tpop, input bit wr, input bit rd,
                       input logic [1:0] a, input logic [31:0] wd);
        @(negedge clk);
        rx_push = push; rx_data = pd; char_tick = tick; tx_pop = tpop;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        #(CLK_P/4);
        if (!rst) compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 2'(i % 4), 0);
    endtask
    task automatic rxin(input logic [7:0] d);
        cyc(1, d, 0, 0, 0, 0, 2'd1, 0);
    endtask
    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        cyc(0, 0, 0, 0, 1, 0, a, d);
    endtask
    task automatic rreg(input logic [1:0] a);
        cyc(0, 0, 0, 0, 0, 1, a, 0);
    endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0, 0, 2'd1, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [12:8] st_before;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        rreg(1); chk("R1", reg_rdata, 32'h0000_1800); chk("R1", 32'(irq), 0);
        rreg(2); chk("R1", reg_rdata, 32'h0001_0808);
        wreg(1, 32'h1F);
        // R2 ordering and empty read
        rxin(8'hA1); rxin(8'hB2); rxin(8'hC3);
        rreg(0); chk("R2", reg_rdata, 32'h1A1);
        rreg(0); chk("R2", reg_rdata, 32'h1B2);
        rreg(0); chk("R2", reg_rdata, 32'h1C3);
        rreg(0); chk("R2", reg_rdata, 32'h0);
        // R4 threshold at 8
        for (int i = 0; i < 7; i++) rxin(8'(i));
        rreg(1); chk("R4", 32'(reg_rdata[9]), 0);
        rxin(8'h07);
        rreg(1); chk("R4", 32'(reg_rdata[9]), 1);
        // R3 overflow
        for (int i = 8; i < 16; i++) rxin(8'(i));
        rreg(1); chk("R3", 32'(reg_rdata[8]), 0);
        rxin(8'hEE);
        cyc(1, 8'hEF, 0, 0, 0, 1, 2'd0, 0);
        rreg(1); chk("R3", 32'(reg_rdata[8]), 1);
        for (int i = 0; i < 16; i++) rreg(0);
        wreg(1, 32'h00);
        rreg(1); chk("R3", 32'(reg_rdata[8]), 1);
        // R9 receive reset
        wreg(2, 32'h4001_0808);
        rreg(1); chk("R9", 32'(reg_rdata[8]), 0);
        rreg(2); chk("R9", 32'(reg_rdata[31:30]), 0);
        wreg(1, 32'h1F);
        // R5 timeout of 3 character times
        wreg(2, 32'h0003_0808);
        rxin(8'h55);
        ticks(2); rreg(1); chk("R5", 32'(reg_rdata[10]), 0);
        ticks(1); rreg(1); chk("R5", 32'(reg_rdata[10]), 1); chk("R11", 32'(irq), 1);
        rxin(8'h56); rreg(1); chk("R5", 32'(reg_rdata[10]), 0);
        wreg(2, 32'h0000_0808);
        ticks(20); rreg(1); chk("R5", 32'(reg_rdata[10]), 0);
        wreg(2, 32'h4001_0808);
        // R6 / R7 / R8 transmit side
        for (int i = 0; i < 5; i++) wreg(0, 32'h11 + 32'(i));
        idle(1); chk("R7", 32'(tx_head), 32'h11);
        rreg(2); chk("R8", 32'(reg_rdata[28:24]), 5);
        rreg(1); chk("R6", 32'(reg_rdata[12:11]), 32'b10);
        for (int i = 0; i < 16; i++) wreg(0, 32'h80 + 32'(i));
        rreg(2); chk("R7", 32'(reg_rdata[28:24]), 16);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, 2'd2, 0);
        rreg(2); chk("R8", 32'(reg_rdata[28:24]), 13);
        rreg(1); chk("R6", 32'(reg_rdata[12:11]), 0);
        wreg(2, 32'h8001_0808);
        rreg(1); chk("R9", 32'(reg_rdata[11]), 1);
        // R10 / R11 mask independence
        rxin(8'h01);
        rreg(1); st_before = reg_rdata[12:8];
        wreg(1, 32'h0);
        rreg(1); chk("R10", 32'(reg_rdata[12:8]), 32'(st_before)); chk("R11", 32'(irq), 0);
        wreg(1, 32'h8);
        rreg(1); chk("R11", 32'(irq), 1);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd = $urandom;
            logic [1:0]  a = 2'($urandom_range(0, 3));
            bit wr = ($urandom_range(0, 9) == 0);
            if (a == 2'd2) begin
                wd[19:16] = 4'($urandom_range(0, 5));
                wd[30] = ($urandom_range(0, 7) == 0);
                wd[31] = ($urandom_range(0, 7) == 0);
            end
            cyc($urandom_range(0, 9) < 4, 8'($urandom), $urandom_range(0, 4) == 0,
                $urandom_range(0, 9) < 3, wr, $urandom_range(0, 9) < 3, a, wd);
        end
        idle(4);
        finish_run();
    end

endmodule